// File: doc/BRIEF.md
# Memory-Mapped Nanosecond Clock with One-Shot Alarm

This peripheral keeps a 64-bit time count in nanoseconds that grows by a fixed step on every clock cycle. Software reaches it through a small 32-bit register bus. It reads the count in two halves, sets either half on its own, and programs a 64-bit compare value that fires once. A single-cycle bus access takes place on any cycle with `busSel` high. Read data is combinational from the registered state in that cycle. Writes take effect at the rising edge.

Reading the low half of the count also copies the upper half into a holding register. A later read of the high word therefore returns a value that matches the low word already read. The alarm is armed only by a write to its low word, after the high word has been set. If the compare value is not ahead of the count at that moment, the alarm fires straight away. A fired alarm sets a pending flag. The interrupt line is the pending flag gated by an enable bit.

Top module: `rtc_alarm_top`

## Requirements
- R1: While reset is low, the count loads `countInit`. The compare value, running flag, pending flag, enable bit and the upper-half holding register all read 0, and `irqOut` is 0.
- R2: Outside of count writes, the count grows by `STEP_NS` on every clock edge and wraps modulo 2^64.
- R3: A read of word 0x00 returns count bits 31:0 and captures count bits 63:32 into the holding register at that edge. A read of 0x04 returns the held value, not the live upper half.
- R4: A write to 0x00 replaces count bits 31:0 and a write to 0x04 replaces bits 63:32; the other half is kept. The step of that cycle is added on top of the written value.
- R5: A write to 0x0C stores compare bits 63:32 only and leaves the running flag unchanged. Reads of 0x08 and 0x0C return compare bits 31:0 and 63:32.
- R6: A write to 0x08 stores compare bits 31:0 and compares the new 64-bit value, unsigned, against the count of that cycle. If it is less than or equal, the pending flag sets and the running flag clears. Otherwise the running flag sets.
- R7: When the running flag is set and the count at an edge is at or past the compare value, the running flag clears and the pending flag sets at that edge.
- R8: `irqOut` is 1 exactly when the pending flag and the enable bit are both 1. A write to 0x10 keeps only data bit 0 as the enable bit, and a read of 0x10 returns it in bit 0.
- R9: A write of any data to 0x14 clears the running flag and leaves the pending flag unchanged. It also suppresses an alarm hit in the same cycle.
- R10: A write to 0x1C clears the pending flag, unless an alarm hit in the same cycle sets it.
- R11: A read of 0x18 returns the running flag in bit 0.
- R12: Reads of 0x14, 0x1C, unaligned addresses or addresses above 0x1C return 0. Writes to unaligned addresses or addresses above 0x1C change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| countInit | input | 64 | Count value loaded during reset |
| busSel | input | 1 | Access in this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W (6) | Byte address of the 32-bit word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| irqOut | output | 1 | Level interrupt |

## Verification
The in-line assertions check, on every edge:
- the fixed-step growth of the count;
- the capture of the upper half on a low-word read;
- that a high compare write leaves the low compare half untouched;
- arming on a future compare value;
- the firing transition of a running alarm;
- the effects of both clear registers.

Other behaviour only the bench scenarios can show, through the bus and the interrupt pin:
- that the held upper half stays stale across a carry;
- that each count half can be written alone, with wrap-around;
- the immediate firing on a past or exactly equal compare value;
- the edge on which a future alarm fires;
- that unmapped and unaligned accesses are ignored.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    REG_TIME_LO  = 3'd0,
    REG_TIME_HI  = 3'd1,
    REG_ALM_LO   = 3'd2,
    REG_ALM_HI   = 3'd3,
    REG_IRQ_EN   = 3'd4,
    REG_ALM_CLR  = 3'd5,
    REG_ALM_STAT = 3'd6,
    REG_IRQ_CLR  = 3'd7
  } regIdx_e;

  typedef struct packed {
    logic wrTimeLo;
    logic wrTimeHi;
    logic wrAlmLo;
    logic wrAlmHi;
    logic rdTimeLo;
  } dpStrobe_t;

endpackage

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int STEP_NS = 10,
  parameter int HALF_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2*HALF_W-1:0]   countInit,
  input  dpStrobe_t             stb,
  input  logic [HALF_W-1:0]     wdata,
  output logic [2*HALF_W-1:0]   countQ,
  output logic [2*HALF_W-1:0]   cmpQ,
  output logic [HALF_W-1:0]     heldHi,
  output logic                  cmpReached,
  output logic                  armPast
);

  localparam int CNT_W = 2 * HALF_W;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(STEP_NS);

  logic [CNT_W-1:0] countBase;
  logic [CNT_W-1:0] cmpArm;

  always_comb begin
    countBase = countQ;
    if (stb.wrTimeLo) countBase[HALF_W-1:0] = wdata;
    if (stb.wrTimeHi) countBase[CNT_W-1:HALF_W] = wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= countInit;
    else       countQ <= countBase + STEP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpQ <= '0;
    end else begin
      if (stb.wrAlmLo) cmpQ[HALF_W-1:0] <= wdata;
      if (stb.wrAlmHi) cmpQ[CNT_W-1:HALF_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             heldHi <= '0;
    else if (stb.rdTimeLo) heldHi <= countQ[CNT_W-1:HALF_W];
  end

  assign cmpArm     = {cmpQ[CNT_W-1:HALF_W], wdata};
  assign armPast    = (cmpArm <= countQ);
  assign cmpReached = (cmpQ <= countQ);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrTimeLo || stb.wrTimeHi) |=> countQ == $past(countQ) + STEP);

  p_hold_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdTimeLo |=> heldHi == $past(countQ[CNT_W-1:HALF_W]));

  p_alarm_hi_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrAlmHi |=> cmpQ[HALF_W-1:0] == $past(cmpQ[HALF_W-1:0]));

endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int HALF_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [HALF_W-1:0]    busWdata,
  input  logic [2*HALF_W-1:0]  countQ,
  input  logic [2*HALF_W-1:0]  cmpQ,
  input  logic [HALF_W-1:0]    heldHi,
  input  logic                 cmpReached,
  input  logic                 armPast,
  output dpStrobe_t            stb,
  output logic [HALF_W-1:0]    busRdata,
  output logic                 pendingQ,
  output logic                 enableQ
);

  localparam int CNT_W = 2 * HALF_W;

  logic    upperZero;
  logic    addrHit;
  regIdx_e idx;
  logic    wrHit, rdHit;
  logic    clrAlm, clrIrq, wrEn;
  logic    runningQ;
  logic    hitNow;

  generate
    if (ADDR_W > 5) begin : g_upper
      assign upperZero = ~|busAddr[ADDR_W-1:5];
    end else begin : g_noupper
      assign upperZero = 1'b1;
    end
  endgenerate

  assign addrHit = upperZero && (busAddr[1:0] == 2'b00);
  assign idx     = regIdx_e'(busAddr[4:2]);
  assign wrHit   = busSel && busWrite && addrHit;
  assign rdHit   = busSel && !busWrite && addrHit;

  assign stb.wrTimeLo = wrHit && (idx == REG_TIME_LO);
  assign stb.wrTimeHi = wrHit && (idx == REG_TIME_HI);
  assign stb.wrAlmLo  = wrHit && (idx == REG_ALM_LO);
  assign stb.wrAlmHi  = wrHit && (idx == REG_ALM_HI);
  assign stb.rdTimeLo = rdHit && (idx == REG_TIME_LO);
  assign clrAlm       = wrHit && (idx == REG_ALM_CLR);
  assign clrIrq       = wrHit && (idx == REG_IRQ_CLR);
  assign wrEn         = wrHit && (idx == REG_IRQ_EN);

  assign hitNow = runningQ && cmpReached && !clrAlm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              runningQ <= 1'b0;
    else if (stb.wrAlmLo)   runningQ <= !armPast;
    else if (clrAlm)        runningQ <= 1'b0;
    else if (hitNow)        runningQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         pendingQ <= 1'b0;
    else if (stb.wrAlmLo && armPast)   pendingQ <= 1'b1;
    else if (hitNow && !stb.wrAlmLo)   pendingQ <= 1'b1;
    else if (clrIrq)                   pendingQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     enableQ <= 1'b0;
    else if (wrEn) enableQ <= busWdata[0];
  end

  always_comb begin
    busRdata = '0;
    if (rdHit) begin
      unique case (idx)
        REG_TIME_LO:  busRdata = countQ[HALF_W-1:0];
        REG_TIME_HI:  busRdata = heldHi;
        REG_ALM_LO:   busRdata = cmpQ[HALF_W-1:0];
        REG_ALM_HI:   busRdata = cmpQ[CNT_W-1:HALF_W];
        REG_IRQ_EN:   busRdata = {{(HALF_W-1){1'b0}}, enableQ};
        REG_ALM_STAT: busRdata = {{(HALF_W-1){1'b0}}, runningQ};
        default:      busRdata = '0;
      endcase
    end
  end

  p_arm_future_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrAlmLo && !armPast) |=> runningQ);

  p_fire_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runningQ && cmpReached && !clrAlm && !stb.wrAlmLo) |=> (pendingQ && !runningQ));

  p_clr_alarm_r9: assert property (@(posedge clk) disable iff (!rstN)
    clrAlm |=> (!runningQ && pendingQ == $past(pendingQ)));

  p_clr_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    (clrIrq && !(runningQ && cmpReached)) |=> !pendingQ);

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_alarm_pkg::*;
#(
  parameter int STEP_NS = 10,
  parameter int ADDR_W  = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2*WORD_W-1:0]  countInit,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [WORD_W-1:0]    busWdata,
  output logic [WORD_W-1:0]    busRdata,
  output logic                 irqOut
);

  localparam int CNT_W = 2 * WORD_W;

  dpStrobe_t          stb;
  logic [CNT_W-1:0]   countQ;
  logic [CNT_W-1:0]   cmpQ;
  logic [WORD_W-1:0]  heldHi;
  logic               cmpReached;
  logic               armPast;
  logic               pendingQ;
  logic               enableQ;

  rtc_alarm_ctrl #(.ADDR_W(ADDR_W), .HALF_W(WORD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .countQ(countQ), .cmpQ(cmpQ),
    .heldHi(heldHi), .cmpReached(cmpReached), .armPast(armPast), .stb(stb),
    .busRdata(busRdata), .pendingQ(pendingQ), .enableQ(enableQ)
  );

  rtc_alarm_dp #(.STEP_NS(STEP_NS), .HALF_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .countInit(countInit), .stb(stb),
    .wdata(busWdata), .countQ(countQ), .cmpQ(cmpQ), .heldHi(heldHi),
    .cmpReached(cmpReached), .armPast(armPast)
  );

  assign irqOut = pendingQ && enableQ;

endmodule

// File: tb/rtc_alarm_top_tb_top.sv
module rtc_alarm_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STEP = 10;
  localparam logic [63:0] INIT = 64'h0000_0001_FFFF_FF00;

  typedef struct packed {
    logic        isWr;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b1, 6'h0C, 32'hFFFF_FFFF, 32'h0, 8'd5},   // R5 high compare, no arm
    '{1'b0, 6'h18, 32'h0, 32'h0, 8'd5},           // R5 still idle
    '{1'b1, 6'h10, 32'hFFFF_FFFE, 32'h0, 8'd8},   // R8 bit0 only
    '{1'b0, 6'h10, 32'h0, 32'h0, 8'd8},
    '{1'b1, 6'h10, 32'h0000_0003, 32'h0, 8'd8},
    '{1'b0, 6'h10, 32'h0, 32'h1, 8'd8},
    '{1'b1, 6'h08, 32'h0000_1234, 32'h0, 8'd6},   // R6 future arm
    '{1'b0, 6'h18, 32'h0, 32'h1, 8'd11},          // R11 running
    '{1'b0, 6'h08, 32'h0, 32'h0000_1234, 8'd5},
    '{1'b0, 6'h0C, 32'h0, 32'hFFFF_FFFF, 8'd5},
    '{1'b0, 6'h14, 32'h0, 32'h0, 8'd12},          // R12 write-only reads
    '{1'b0, 6'h1C, 32'h0, 32'h0, 8'd12},
    '{1'b1, 6'h14, 32'hDEAD_BEEF, 32'h0, 8'd9},   // R9 disarm
    '{1'b0, 6'h18, 32'h0, 32'h0, 8'd9}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic [63:0] m;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_top dut_i (
    .clk(clk), .rstN(rstN), .countInit(INIT), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  // requirement model of the count (R2, R4)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) m <= INIT;
    else if (busSel && busWrite && busAddr == 6'h00) m <= {m[63:32], busWdata} + 64'(STEP);
    else if (busSel && busWrite && busAddr == 6'h04) m <= {busWdata, m[31:0]} + 64'(STEP);
    else m <= m + 64'(STEP);
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic [63:0] snap);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata; snap = m;
    @(posedge clk); #1;
    busSel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] s;
    logic [31:0] heldExp;
    logic [63:0] target;

    repeat (3) @(negedge clk);
    check("R1 irq in reset", irqOut, 0);
    rstN = 1;
    rd(6'h08, d, s); check("R1 cmp lo", d, 0);
    rd(6'h0C, d, s); check("R1 cmp hi", d, 0);
    rd(6'h10, d, s); check("R1 enable", d, 0);
    rd(6'h18, d, s); check("R1 running", d, 0);
    rd(6'h04, d, s); check("R1 held", d, 0);
    rd(6'h00, d, s); check("R1 count lo", d, s[31:0]);

    foreach (VECS[i]) begin
      if (VECS[i].isWr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, d, s);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), d, VECS[i].expv);
      end
    end
    check("R12 irq quiet", irqOut, 0);

    // R3 stale held half across a carry
    wr(6'h04, 32'd5);
    wr(6'h00, 32'hFFFF_FFC0);
    rd(6'h00, d, s); heldExp = s[63:32];
    check("R4 lo write", d, s[31:0]);
    check("R3 pre-carry high", heldExp, 5);
    idle(10);
    rd(6'h04, d, s); check("R3 held stale", d, heldExp);
    rd(6'h00, d, s); heldExp = s[63:32];
    rd(6'h04, d, s); check("R3 held refresh", d, 6);
    check("R2 carry model", heldExp, 6);

    // R4 low-half write keeps the high half
    wr(6'h00, 32'h0000_1000);
    rd(6'h00, d, s); check("R4 lo replaced", d, s[31:0]);
    rd(6'h04, d, s); check("R4 hi kept", d, 6);

    // R2 wrap
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h00, 32'hFFFF_FFE0);
    idle(5);
    rd(6'h00, d, s); check("R2 wrap lo", d, s[31:0]);
    rd(6'h04, d, s); check("R2 wrap hi", d, 0);

    // R6 past value fires at once, R8 gating, R10 clear
    wr(6'h0C, 32'h0);
    wr(6'h08, 32'h0);
    check("R6 past fires", irqOut, 1);
    rd(6'h18, d, s); check("R6 not running", d, 0);
    wr(6'h10, 32'h0); check("R8 gated off", irqOut, 0);
    wr(6'h10, 32'h1); check("R8 gated on", irqOut, 1);
    wr(6'h1C, 32'h0); check("R10 cleared", irqOut, 0);

    // R6 equal value fires at once
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 6'h08; busWdata = m[31:0];
    @(posedge clk); #1; busSel = 0; busWrite = 0;
    check("R6 equal fires", irqOut, 1);
    wr(6'h1C, 32'h0);

    // R7 future alarm fires on the edge it is reached
    target = m + 64'd200;
    wr(6'h0C, target[63:32]);
    wr(6'h08, target[31:0]);
    rd(6'h18, d, s); check("R6 armed", d, 1);
    check("R7 not yet", irqOut, 0);
    while (m < target) @(negedge clk);
    check("R7 before edge", irqOut, 0);
    @(posedge clk); #1;
    check("R7 fired", irqOut, 1);
    rd(6'h18, d, s); check("R7 running clear", d, 0);

    // R9 disarm keeps pending
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h08, 32'h0);
    rd(6'h18, d, s); check("R9 armed", d, 1);
    wr(6'h14, 32'h0);
    rd(6'h18, d, s); check("R9 disarmed", d, 0);
    check("R9 pending kept", irqOut, 1);
    wr(6'h1C, 32'h0);
    target = m + 64'd100;
    wr(6'h0C, target[63:32]);
    wr(6'h08, target[31:0]);
    wr(6'h14, 32'h0);
    idle(30);
    check("R9 no fire after clear", irqOut, 0);

    // R12 unmapped and unaligned writes ignored
    wr(6'h28, 32'hFFFF_FFFF);
    wr(6'h12, 32'h0);
    wr(6'h0E, 32'h1234_5678);
    rd(6'h10, d, s); check("R12 enable kept", d, 1);
    rd(6'h0C, d, s); check("R12 cmp hi kept", d, target[63:32]);
    rd(6'h28, d, s); check("R12 unmapped read", d, 0);
    rd(6'h02, d, s); check("R12 unaligned read", d, 0);
    check("R12 irq kept", irqOut, 0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule